// File: doc/BRIEF.md
# Capability Page-Permission Checker

This block sits next to a page-table walker or TLB and rules on each memory access against two per-page capability bits. The first bit, page-capability-write (CW), says whether tagged capabilities may move to and from the page. The second bit, page-capability-generation (CRG), marks the revocation epoch the page last belonged to. For every accepted access the checker returns a registered verdict. The verdict is either no fault, a load page fault or a store page fault, together with the tag the loaded capability keeps after the permission and page rules.

Two parts of its behaviour can be configured. In the first, a tagged capability store to a page in the "CW clear, CRG set" state can, instead of faulting, ask the walker to rewrite the entry atomically with CW set and CRG copied from the global generation bit. The access is held while this request is outstanding. In the second, the stale-generation load fault can be made to depend on the tag of the capability read from memory, or raised whatever that tag is.

Access kinds on `req_kind` are 0 capability load, 1 capability store, 2 capability atomic (both a load and a store), and 3 plain non-capability access. Page formats on `req_mode` are 0 for the 32-bit format, and 1, 2 and 3 for the 39, 48 and 57-bit formats. The sequencer has three states:
- ST_IDLE accepts accesses.
- ST_UPD_OFFER presents the update request.
- ST_UPD_WAIT waits for the walker's completion.

There are three transitions:
- IDLE→OFFER on accepting an access whose verdict is an update.
- OFFER→WAIT when `upd_ready` is high.
- WAIT→IDLE when `upd_done` is high.

Top module: `cap_pte_check`

## Requirements
- R1: In the 32-bit format (`req_mode`=0) CW and CRG have no effect. No fault is raised, no update is requested, and the load tag depends only on the permissions and the memory tag.
- R2: In formats 1–3, a non-leaf entry with CW or CRG nonzero raises a page fault. The fault is a store page fault for kinds 1 and 2, and a load page fault for kinds 0 and 3. This fault ranks above every other verdict.
- R3: The returned tag `rsp_tag` is 0 unless the access is kind 0 or 2, `ld_tag` is 1, and both `auth_rd` and `auth_cap` are 1.
- R4: The store tag used by the page rules is `st_tag` AND `auth_cap` AND NOT `lvl_clr`. When it is 0, a store or atomic raises no store fault and requests no update.
- R5: On a leaf page in formats 1–3 with CW=0 and CRG=0, a capability store or atomic with a set store tag raises a store page fault.
- R6: With CW=0 and CRG=1, a tagged store or atomic raises a store page fault when `cfg_hw_upd`=0. When `cfg_hw_upd`=1 it instead requests an update with `upd_cw`=1 and `upd_crg` equal to `gen_cur` at acceptance.
- R7: While an update is outstanding, `req_ready` is 0. `upd_valid` and `upd_crg` stay stable until `upd_ready`. The response follows `upd_done`: no fault if `upd_ok`=1, and a store page fault otherwise. After a successful update an atomic returns its tag as on a CW=1 page.
- R8: On a leaf page in formats 1–3 with CW=1 and `auth_cap`=1, a capability load or atomic whose CRG differs from `gen_cur` raises a load page fault. When `cfg_gen_tag`=1, this fault also requires `ld_tag`=1.
- R9: A capability load from a leaf page in formats 1–3 with CW=0 returns `rsp_tag`=0 and raises no fault.
- R10: `rsp_ld_fault` and `rsp_st_fault` are never both 1, and neither is 1 without `rsp_valid`.
- R11: After reset `req_ready`=1 and `rsp_valid`=0. An access accepted at a clock edge with no update produces `rsp_valid` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access presented |
| req_ready | output | 1 | Checker can accept an access |
| req_kind | input | 2 | Access kind (0 cap load, 1 cap store, 2 cap atomic, 3 plain) |
| req_leaf | input | 1 | Entry is a leaf |
| req_mode | input | 2 | Page format (0 = 32-bit, 1..3 = 39/48/57-bit) |
| pte_cw | input | 1 | Page capability-write bit |
| pte_crg | input | 1 | Page generation bit |
| auth_rd | input | 1 | Authorizing capability grants read |
| auth_cap | input | 1 | Authorizing capability grants capability access |
| lvl_clr | input | 1 | Store tag already cleared by a permission-level rule |
| st_tag | input | 1 | Tag of the capability being stored |
| ld_tag | input | 1 | Tag of the capability read from memory |
| gen_cur | input | 1 | Global generation bit |
| cfg_hw_upd | input | 1 | 1 = hardware sets CW on tagged store to CW=0/CRG=1 page |
| cfg_gen_tag | input | 1 | 1 = generation fault requires loaded tag set |
| upd_valid | output | 1 | Entry-update request |
| upd_ready | input | 1 | Walker accepts the update request |
| upd_cw | output | 1 | New CW value |
| upd_crg | output | 1 | New CRG value |
| upd_done | input | 1 | Walker finished the update attempt |
| upd_ok | input | 1 | Update written (0 = aborted on re-check) |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ld_fault | output | 1 | Load page fault |
| rsp_st_fault | output | 1 | Store page fault |
| rsp_tag | output | 1 | Tag kept by the loaded capability |

## Verification
The assertions assume the walker raises `upd_done` only in the cycles after it has taken an update request with `upd_ready`. They also assume it raises `upd_ready` only while `upd_valid` is high, and that access inputs hold steady while `req_valid` is high. The bench keeps to this by driving a single access at a time and dropping `req_valid` right after acceptance. It drives `upd_ready` only after it has seen `upd_valid`, and drives `upd_done` only after the request handshake. It sets every field of the access explicitly in each call, so no value is left over from the previous access.

// File: rtl/cap_pte_pkg.sv
package cap_pte_pkg;
    localparam int KIND_W = 2;
    localparam int FMT_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        ACC_CLD   = 2'd0,
        ACC_CST   = 2'd1,
        ACC_CAMO  = 2'd2,
        ACC_PLAIN = 2'd3
    } acc_kind_t;

    typedef enum logic [FMT_W-1:0] {
        FMT_32 = 2'd0,
        FMT_39 = 2'd1,
        FMT_48 = 2'd2,
        FMT_57 = 2'd3
    } pte_fmt_t;

    typedef enum logic [1:0] {
        VERD_PASS   = 2'd0,
        VERD_LDFLT  = 2'd1,
        VERD_STFLT  = 2'd2,
        VERD_UPDATE = 2'd3
    } verdict_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_UPD_OFFER = 2'd1,
        ST_UPD_WAIT  = 2'd2
    } chk_state_t;

    typedef struct packed {
        verdict_t verd;
        logic     tag;
        logic     new_crg;
    } decision_t;
endpackage

// File: rtl/cap_pte_rules.sv
module cap_pte_rules
    import cap_pte_pkg::*;
(
    input  acc_kind_t kind,
    input  pte_fmt_t  fmt,
    input  logic      leaf,
    input  logic      cw,
    input  logic      crg,
    input  logic      auth_rd,
    input  logic      auth_cap,
    input  logic      lvl_clr,
    input  logic      st_tag,
    input  logic      ld_tag,
    input  logic      gen_cur,
    input  logic      cfg_hw_upd,
    input  logic      cfg_gen_tag,
    output decision_t dec
);
    logic is_ld, is_st, ext_fmt, cap_pg, rsv_hit;
    logic st_tag_eff, wr_blk, wr_upd, gen_hit;
    logic tag_perm, tag_now;

    always_comb begin
        is_ld      = (kind == ACC_CLD) || (kind == ACC_CAMO);
        is_st      = (kind == ACC_CST) || (kind == ACC_CAMO);
        ext_fmt    = (fmt != FMT_32);
        cap_pg     = ext_fmt && leaf;
        rsv_hit    = ext_fmt && !leaf && (cw || crg);
        st_tag_eff = st_tag && auth_cap && !lvl_clr;
        wr_blk     = cap_pg && is_st && st_tag_eff && !cw;
        wr_upd     = wr_blk && crg && cfg_hw_upd;
        gen_hit    = cap_pg && is_ld && cw && auth_cap && (crg != gen_cur)
                     && (!cfg_gen_tag || ld_tag);
        tag_perm   = is_ld && ld_tag && auth_rd && auth_cap;
        tag_now    = tag_perm && (!cap_pg || cw);
    end

    always_comb begin
        dec.new_crg = gen_cur;
        dec.tag     = 1'b0;
        if (rsv_hit) begin
            dec.verd = is_st ? VERD_STFLT : VERD_LDFLT;
        end else if (wr_upd) begin
            dec.verd = VERD_UPDATE;
            dec.tag  = tag_perm;
        end else if (wr_blk) begin
            dec.verd = VERD_STFLT;
        end else if (gen_hit) begin
            dec.verd = VERD_LDFLT;
        end else begin
            dec.verd = VERD_PASS;
            dec.tag  = tag_now;
        end
    end
endmodule

// File: rtl/cap_pte_fsm.sv
module cap_pte_fsm
    import cap_pte_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  decision_t dec,
    input  logic      upd_ready,
    input  logic      upd_done,
    input  logic      upd_ok,
    output logic      req_ready,
    output logic      upd_valid,
    output logic      upd_cw,
    output logic      upd_crg,
    output logic      fin_pulse,
    output verdict_t  fin_verd,
    output logic      fin_tag
);
    chk_state_t state_q, state_d;
    logic held_crg, held_tag;
    logic accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_crg <= 1'b0;
            held_tag <= 1'b0;
        end else if (accept && dec.verd == VERD_UPDATE) begin
            held_crg <= dec.new_crg;
            held_tag <= dec.tag;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept && dec.verd == VERD_UPDATE) state_d = ST_UPD_OFFER;
            ST_UPD_OFFER: if (upd_ready) state_d = ST_UPD_WAIT;
            ST_UPD_WAIT:  if (upd_done)  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        upd_valid = 1'b0;
        fin_pulse = 1'b0;
        fin_verd  = VERD_PASS;
        fin_tag   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (accept && dec.verd != VERD_UPDATE) begin
                    fin_pulse = 1'b1;
                    fin_verd  = dec.verd;
                    fin_tag   = dec.tag;
                end
            end
            ST_UPD_OFFER: upd_valid = 1'b1;
            ST_UPD_WAIT: begin
                if (upd_done) begin
                    fin_pulse = 1'b1;
                    fin_verd  = upd_ok ? VERD_PASS : VERD_STFLT;
                    fin_tag   = upd_ok && held_tag;
                end
            end
            default: ;
        endcase
    end

    assign upd_cw  = upd_valid;
    assign upd_crg = held_crg;
endmodule

// File: rtl/cap_pte_resp.sv
module cap_pte_resp
    import cap_pte_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fin_pulse,
    input  verdict_t fin_verd,
    input  logic     fin_tag,
    output logic     rsp_valid,
    output logic     rsp_ld_fault,
    output logic     rsp_st_fault,
    output logic     rsp_tag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_ld_fault <= 1'b0;
            rsp_st_fault <= 1'b0;
            rsp_tag      <= 1'b0;
        end else begin
            rsp_valid    <= fin_pulse;
            rsp_ld_fault <= fin_pulse && (fin_verd == VERD_LDFLT);
            rsp_st_fault <= fin_pulse && (fin_verd == VERD_STFLT);
            rsp_tag      <= fin_pulse && fin_tag;
        end
    end
endmodule

// File: rtl/cap_pte_check.sv
module cap_pte_check
    import cap_pte_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic             req_leaf,
    input  logic [FMT_W-1:0] req_mode,
    input  logic             pte_cw,
    input  logic             pte_crg,
    input  logic             auth_rd,
    input  logic             auth_cap,
    input  logic             lvl_clr,
    input  logic             st_tag,
    input  logic             ld_tag,
    input  logic             gen_cur,
    input  logic             cfg_hw_upd,
    input  logic             cfg_gen_tag,
    output logic             upd_valid,
    input  logic             upd_ready,
    output logic             upd_cw,
    output logic             upd_crg,
    input  logic             upd_done,
    input  logic             upd_ok,
    output logic             rsp_valid,
    output logic             rsp_ld_fault,
    output logic             rsp_st_fault,
    output logic             rsp_tag
);
    decision_t dec;
    logic      fin_pulse, fin_tag;
    verdict_t  fin_verd;

    cap_pte_rules u_rules (
        .kind        (acc_kind_t'(req_kind)),
        .fmt         (pte_fmt_t'(req_mode)),
        .leaf        (req_leaf),
        .cw          (pte_cw),
        .crg         (pte_crg),
        .auth_rd     (auth_rd),
        .auth_cap    (auth_cap),
        .lvl_clr     (lvl_clr),
        .st_tag      (st_tag),
        .ld_tag      (ld_tag),
        .gen_cur     (gen_cur),
        .cfg_hw_upd  (cfg_hw_upd),
        .cfg_gen_tag (cfg_gen_tag),
        .dec         (dec)
    );

    cap_pte_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .dec       (dec),
        .upd_ready (upd_ready),
        .upd_done  (upd_done),
        .upd_ok    (upd_ok),
        .req_ready (req_ready),
        .upd_valid (upd_valid),
        .upd_cw    (upd_cw),
        .upd_crg   (upd_crg),
        .fin_pulse (fin_pulse),
        .fin_verd  (fin_verd),
        .fin_tag   (fin_tag)
    );

    cap_pte_resp u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .fin_pulse    (fin_pulse),
        .fin_verd     (fin_verd),
        .fin_tag      (fin_tag),
        .rsp_valid    (rsp_valid),
        .rsp_ld_fault (rsp_ld_fault),
        .rsp_st_fault (rsp_st_fault),
        .rsp_tag      (rsp_tag)
    );
endmodule

// File: rtl/cap_pte_check_sva.sv
module cap_pte_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       req_leaf,
    input logic [1:0] req_mode,
    input logic       pte_cw,
    input logic       pte_crg,
    input logic       auth_rd,
    input logic       auth_cap,
    input logic       lvl_clr,
    input logic       st_tag,
    input logic       gen_cur,
    input logic       cfg_hw_upd,
    input logic       upd_valid,
    input logic       upd_ready,
    input logic       upd_crg,
    input logic       upd_done,
    input logic       rsp_valid,
    input logic       rsp_ld_fault,
    input logic       rsp_st_fault,
    input logic       rsp_tag
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_SV32_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_mode == 2'd0 |=> rsp_valid && !rsp_ld_fault && !rsp_st_fault && !upd_valid); // R1

    AST_RSV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_mode != 2'd0 && !req_leaf && (pte_cw || pte_crg) |=> rsp_ld_fault || rsp_st_fault); // R2

    AST_TAG_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !(auth_rd && auth_cap) |=> !rsp_tag); // R3

    AST_UPD_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_mode != 2'd0 && req_leaf && !pte_cw && pte_crg && cfg_hw_upd
        && st_tag && auth_cap && !lvl_clr && (req_kind == 2'd1 || req_kind == 2'd2)
        |=> upd_valid && upd_crg == $past(gen_cur)); // R6

    AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_ready |=> upd_valid && $stable(upd_crg)); // R7

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !req_ready); // R7

    AST_FLT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_ld_fault, rsp_st_fault})); // R10

    AST_FLT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ld_fault || rsp_st_fault || rsp_tag) |-> rsp_valid); // R10

    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc) || $past(upd_done && !req_ready && !upd_valid)); // R11
endmodule

bind cap_pte_check cap_pte_check_sva u_sva (.*);

// File: tb/cap_pte_check_tb.sv
module cap_pte_check_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  lf;
        logic  sf;
        logic  tg;
        string rq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_leaf = 0, pte_cw = 0, pte_crg = 0;
    logic auth_rd = 0, auth_cap = 0, lvl_clr = 0, st_tag = 0, ld_tag = 0;
    logic gen_cur = 0, cfg_hw_upd = 0, cfg_gen_tag = 0;
    logic upd_ready = 0, upd_done = 0, upd_ok = 0;
    logic [1:0] req_kind = 0, req_mode = 0;
    logic req_ready, upd_valid, upd_cw, upd_crg;
    logic rsp_valid, rsp_ld_fault, rsp_st_fault, rsp_tag;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_pte_check dut_i (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R11", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_ld_fault == e.lf && rsp_st_fault == e.sf && rsp_tag == e.tg,
                    e.rq, "ld/st/tag",
                    {rsp_ld_fault, rsp_st_fault, rsp_tag}, {e.lf, e.sf, e.tg});
            end
        end
    end

    // Expected verdict from the requirements (no update path)
    function automatic exp_t model(input string rq);
        exp_t e;
        bit ld = (req_kind == 0) || (req_kind == 2);
        bit st = (req_kind == 1) || (req_kind == 2);
        bit capg = (req_mode != 0) && req_leaf;
        bit rsv = (req_mode != 0) && !req_leaf && (pte_cw || pte_crg);
        bit stt = st_tag && auth_cap && !lvl_clr;
        bit perm_tag = ld && ld_tag && auth_rd && auth_cap;
        e.rq = rq; e.lf = 0; e.sf = 0; e.tg = 0;
        if (rsv) begin
            e.sf = st; e.lf = !st;
        end else if (capg && st && stt && !pte_cw) begin
            e.sf = 1;
        end else if (capg && ld && pte_cw && auth_cap && pte_crg != gen_cur
                     && (!cfg_gen_tag || ld_tag)) begin
            e.lf = 1;
        end else begin
            e.tg = perm_tag && (!capg || pte_cw);
        end
        return e;
    endfunction

    task automatic setup(input int kind, input bit leaf, input int mode,
                         input bit cw, input bit crg, input bit rd, input bit cap,
                         input bit lvl, input bit stg, input bit ltg, input bit gen,
                         input bit hw, input bit gt);
        req_kind = kind[1:0]; req_leaf = leaf; req_mode = mode[1:0];
        pte_cw = cw; pte_crg = crg; auth_rd = rd; auth_cap = cap; lvl_clr = lvl;
        st_tag = stg; ld_tag = ltg; gen_cur = gen; cfg_hw_upd = hw; cfg_gen_tag = gt;
    endtask

    task automatic launch();
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    // Driver for a plain-verdict access
    task automatic access(input string rq, input int kind, input bit leaf, input int mode,
                          input bit cw, input bit crg, input bit rd, input bit cap,
                          input bit lvl, input bit stg, input bit ltg, input bit gen,
                          input bit hw, input bit gt);
        @(negedge clk);
        setup(kind, leaf, mode, cw, crg, rd, cap, lvl, stg, ltg, gen, hw, gt);
        sb.push_back(model(rq));
        launch();
        @(posedge clk); #1;
        chk(sb.size() == 0, "R11", "response one cycle after accept", sb.size(), 0);
    endtask

    // Driver for an access that requests an entry update
    task automatic upd_access(input int kind, input bit ltg, input bit gen, input bit ok);
        exp_t e;
        @(negedge clk);
        setup(kind, 1, 1, 0, 1, 1, 1, 0, 1, ltg, gen, 1, 0);
        e.rq = "R7"; e.lf = 0; e.sf = !ok;
        e.tg = ok && (kind == 2) && ltg;
        launch();
        chk(upd_valid && upd_cw && upd_crg == gen, "R6", "update request cw/crg",
            {upd_valid, upd_cw, upd_crg}, {1'b1, 1'b1, gen});
        chk(!req_ready, "R7", "busy during update", req_ready, 0);
        gen_cur = !gen;
        @(negedge clk);
        chk(upd_valid && upd_crg == gen, "R7", "request held until ready",
            {upd_valid, upd_crg}, {1'b1, gen});
        upd_ready = 1;
        @(negedge clk);
        upd_ready = 0;
        chk(!upd_valid && !req_ready && !rsp_valid, "R7", "waiting for completion",
            {upd_valid, req_ready, rsp_valid}, 0);
        sb.push_back(e);
        upd_done = 1; upd_ok = ok;
        @(negedge clk);
        upd_done = 0; upd_ok = 0;
        @(posedge clk); #1;
        chk(sb.size() == 0, "R7", "response after completion", sb.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !upd_valid, "R11", "reset state",
            {req_ready, rsp_valid, upd_valid}, 3'b100);
        rst_n = 1;
        //     rq   kind leaf mode cw crg rd cap lvl stg ltg gen hw gt
        access("R1", 1, 1, 0, 0, 0, 1, 1, 0, 1, 0, 0, 1, 0);
        access("R1", 0, 1, 0, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0);
        access("R2", 0, 0, 1, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0);
        access("R2", 1, 0, 3, 0, 1, 1, 1, 0, 1, 0, 0, 1, 0);
        access("R2", 3, 0, 2, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
        access("R3", 0, 1, 1, 1, 0, 0, 1, 0, 0, 1, 0, 0, 0);
        access("R3", 0, 1, 2, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0);
        access("R3", 2, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 0, 0);
        access("R4", 1, 1, 1, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0);
        access("R4", 2, 1, 1, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0);
        access("R4", 1, 1, 1, 0, 1, 1, 1, 0, 0, 0, 0, 1, 0);
        access("R5", 1, 1, 1, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0);
        access("R5", 2, 1, 3, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0);
        access("R6", 1, 1, 2, 0, 1, 1, 1, 0, 1, 0, 1, 0, 0);
        access("R8", 0, 1, 1, 1, 0, 1, 1, 0, 0, 1, 1, 0, 0);
        access("R8", 0, 1, 1, 1, 0, 1, 1, 0, 0, 0, 1, 0, 1);
        access("R8", 2, 1, 1, 1, 1, 1, 1, 0, 0, 1, 0, 0, 1);
        access("R8", 0, 1, 1, 1, 1, 1, 0, 0, 0, 1, 0, 0, 0);
        access("R8", 0, 1, 1, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0);
        access("R9", 0, 1, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0);
        access("R9", 0, 1, 3, 0, 1, 1, 1, 0, 0, 1, 1, 1, 1);
        access("R10", 2, 0, 1, 1, 1, 1, 1, 0, 1, 1, 0, 1, 0);
        upd_access(1, 0, 1, 1);
        upd_access(1, 0, 0, 0);
        upd_access(2, 1, 0, 1);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule